// File: doc/BRIEF.md
# Synchronous CAM Lookup Port

This block is the clocked lookup side of a 16-entry content-addressable table. Each entry holds a key, a valid bit, a virtual-path flag and a data word. The table contents reach the block as flat input vectors from separate storage. A caller places a 32-bit key on the match bus and raises a start strobe. The block samples that key on the same rising edge and searches every entry in parallel. Two edges later it gives a one-cycle completion pulse, together with a hit flag and a virtual-path hit flag. The data word of the winning entry stays in a result register and reaches the data output only while output-enable is high.

Keys wider than the bus are built in two steps. A separate low-word strobe first stores the low 32 bits. In wide mode, the word on the bus at start time then supplies the upper bits. The start strobe may follow either of two timing styles. The strobe may be held for two cycles with the key valid only in the first. Or the strobe may last a single cycle with the key held for two. Only the rising edge of the strobe begins a lookup, so both styles give the same result.

Top module: `cam_match_port`

## Requirements
- R1: A lookup starts only on a clock edge where the start strobe is high and was low at the previous edge. The key is taken from the match bus at that edge. A strobe that stays high on the following edge does not start a second lookup.
- R2: The completion output is a one-cycle pulse. It is high during the cycle that follows the second rising edge after the start edge, and low before and after that cycle.
- R3: The hit output is high together with the completion pulse when at least one valid entry matches the key. It is low at all other times.
- R4: The virtual-path hit output is high together with the hit output only when ATM mode was high at the start edge and the winning entry has its virtual-path flag set.
- R5: When several entries match, the entry with the lowest index supplies the result data and the virtual-path flag.
- R6: The data output carries the result of the last completed lookup while output-enable is high. It is zero while output-enable is low. The result stays in place after the completion pulse ends.
- R7: In wide mode, the low-word strobe stores the match bus as key bits 31:0. This stored word is kept until the next low-word strobe. The bus value at the start edge supplies key bits 63:32, and all 64 bits are compared.
- R8: In narrow mode, only entry key bits 31:0 are compared with the bus value. Entry bits 63:32 are ignored.
- R9: A held-strobe start and a single-cycle-strobe start with the same key give identical results.
- R10: After reset, completion, hit and virtual-path hit are low, and the data output is zero.
- R11: An entry whose valid bit is low never matches. A lookup that finds no match leaves hit low and sets the result data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| matchBus | input | 32 | Key word for a lookup or for a low-word capture |
| startStrobe | input | 1 | Lookup start; its rising edge is acted on |
| lowStrobe | input | 1 | Stores matchBus as the low key word |
| wideMode | input | 1 | 1: compare 64-bit keys, 0: compare 32 bits |
| atmMode | input | 1 | Enables virtual-path hit reporting |
| outEnable | input | 1 | Drives the result data onto dataOut |
| entryKeys | input | 1024 | Entry keys, entry i at bits [64i+63:64i] |
| entryValid | input | 16 | Per-entry valid bit |
| entryVirtPath | input | 16 | Per-entry virtual-path flag |
| entryData | input | 256 | Entry data, entry i at bits [16i+15:16i] |
| matchDone | output | 1 | One-cycle lookup completion pulse |
| matchHit | output | 1 | Match found, valid with matchDone |
| virtPathHit | output | 1 | Virtual-path match, valid with matchHit |
| dataOut | output | 16 | Result data, or zero when outEnable is low |

## Verification
A start-edge detector that retriggers shows up as a second completion pulse, one cycle after the expected one. A pipeline stage that is missing or doubled moves the pulse by one cycle. Both faults are visible at the completion output within four edges of the strobe. A wrong key register or a stale low-word latch returns the data of another entry on the very next pulse. A faulty priority order shows when several entries share a key. A result register that clears at the end of the pulse shows on dataOut one cycle later.

// File: rtl/cam_match_pkg.sv
package cam_match_pkg;

  // Per-cycle steps the control issues to the datapath
  typedef struct packed {
    logic capture;   // sample key and mode bits
    logic evaluate;  // register compare result
    logic publish;   // move result to the output registers
  } stepCtrl_t;

endpackage

// File: rtl/cam_match_ctrl.sv
module cam_match_ctrl
  import cam_match_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStrobe,
  output stepCtrl_t step,
  output logic      doneOut
);

  logic strobePrev;
  logic stageOne;
  logic stageTwo;
  logic doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      stageOne   <= 1'b0;
      stageTwo   <= 1'b0;
      doneReg    <= 1'b0;
    end else begin
      strobePrev <= startStrobe;
      stageOne   <= startStrobe & ~strobePrev;
      stageTwo   <= stageOne;
      doneReg    <= stageTwo;
    end
  end

  always_comb begin
    step.capture  = startStrobe & ~strobePrev;
    step.evaluate = stageOne;
    step.publish  = stageTwo;
  end

  assign doneOut = doneReg;

endmodule

// File: rtl/cam_match_datapath.sv
module cam_match_datapath
  import cam_match_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int MATCH_W = 32,
  parameter int KEY_W   = 64,   // MATCH_W < KEY_W <= 2*MATCH_W
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  stepCtrl_t                  step,
  input  logic [MATCH_W-1:0]         matchBus,
  input  logic                       lowStrobe,
  input  logic                       wideMode,
  input  logic                       atmMode,
  input  logic [ENTRIES*KEY_W-1:0]   entryKeys,
  input  logic [ENTRIES-1:0]         entryValid,
  input  logic [ENTRIES-1:0]         entryVirtPath,
  input  logic [ENTRIES*DATA_W-1:0]  entryData,
  output logic                       resHit,
  output logic                       resVp,
  output logic [DATA_W-1:0]          resData
);

  localparam int HIGH_W = KEY_W - MATCH_W;
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [MATCH_W-1:0] lowWord;
  logic [KEY_W-1:0]   keyReg;
  logic               wideReg;
  logic               atmReg;
  logic [ENTRIES-1:0] hitVec;
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;
  logic               stHit;
  logic               stVp;
  logic [DATA_W-1:0]  stData;

  // Low word of a wide key, kept until the next low strobe
  always_ff @(posedge clk) begin
    if (!rstN)          lowWord <= '0;
    else if (lowStrobe) lowWord <= matchBus;
  end

  // Key and mode capture at the start edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg  <= '0;
      wideReg <= 1'b0;
      atmReg  <= 1'b0;
    end else if (step.capture) begin
      keyReg  <= wideMode ? {matchBus[HIGH_W-1:0], lowWord}
                          : {{HIGH_W{1'b0}}, matchBus};
      wideReg <= wideMode;
      atmReg  <= atmMode;
    end
  end

  // One comparator per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic eqLow;
    logic eqHigh;
    assign eqLow  = entryKeys[e*KEY_W +: MATCH_W] == keyReg[MATCH_W-1:0];
    assign eqHigh = entryKeys[e*KEY_W+MATCH_W +: HIGH_W] == keyReg[KEY_W-1:MATCH_W];
    assign hitVec[e] = entryValid[e] & eqLow & (eqHigh | ~wideReg);
  end

  // Lowest index wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stHit   <= 1'b0;
      stVp    <= 1'b0;
      stData  <= '0;
      resHit  <= 1'b0;
      resVp   <= 1'b0;
      resData <= '0;
    end else begin
      if (step.evaluate) begin
        stHit  <= anyHit;
        stVp   <= anyHit & atmReg & entryVirtPath[winIdx];
        stData <= anyHit ? entryData[int'(winIdx)*DATA_W +: DATA_W] : '0;
      end
      if (step.publish) begin
        resHit  <= stHit;
        resVp   <= stVp;
        resData <= stData;
      end
    end
  end

endmodule

// File: rtl/cam_match_port.sv
module cam_match_port
  import cam_match_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int MATCH_W = 32,
  parameter int KEY_W   = 64,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [MATCH_W-1:0]        matchBus,
  input  logic                      startStrobe,
  input  logic                      lowStrobe,
  input  logic                      wideMode,
  input  logic                      atmMode,
  input  logic                      outEnable,
  input  logic [ENTRIES*KEY_W-1:0]  entryKeys,
  input  logic [ENTRIES-1:0]        entryValid,
  input  logic [ENTRIES-1:0]        entryVirtPath,
  input  logic [ENTRIES*DATA_W-1:0] entryData,
  output logic                      matchDone,
  output logic                      matchHit,
  output logic                      virtPathHit,
  output logic [DATA_W-1:0]         dataOut
);

  stepCtrl_t         step;
  logic              doneInt;
  logic              resHit;
  logic              resVp;
  logic [DATA_W-1:0] resData;

  cam_match_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .step        (step),
    .doneOut     (doneInt)
  );

  cam_match_datapath #(
    .ENTRIES (ENTRIES),
    .MATCH_W (MATCH_W),
    .KEY_W   (KEY_W),
    .DATA_W  (DATA_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .step          (step),
    .matchBus      (matchBus),
    .lowStrobe     (lowStrobe),
    .wideMode      (wideMode),
    .atmMode       (atmMode),
    .entryKeys     (entryKeys),
    .entryValid    (entryValid),
    .entryVirtPath (entryVirtPath),
    .entryData     (entryData),
    .resHit        (resHit),
    .resVp         (resVp),
    .resData       (resData)
  );

  assign matchDone   = doneInt;
  assign matchHit    = doneInt & resHit;
  assign virtPathHit = doneInt & resVp;
  assign dataOut     = outEnable ? resData : '0;

endmodule

// File: rtl/cam_match_checker.sv
module cam_match_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStrobe,
  input logic              atmMode,
  input logic              outEnable,
  input logic              matchDone,
  input logic              matchHit,
  input logic              virtPathHit,
  input logic [DATA_W-1:0] dataOut
);

  logic prevStrobe;
  logic startSeen;

  always_ff @(posedge clk) begin
    if (!rstN) prevStrobe <= 1'b0;
    else       prevStrobe <= startStrobe;
  end

  assign startSeen = startStrobe & ~prevStrobe;

  p_start_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> ##2 matchDone);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    matchDone |=> !matchDone);

  p_done_has_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    matchDone |-> $past(startSeen, 3));

  p_hit_with_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> matchDone);

  p_vp_with_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    virtPathHit |-> matchHit);

  p_vp_needs_atm_r4: assert property (@(posedge clk) disable iff (!rstN)
    virtPathHit |-> $past(atmMode, 3));

  p_oe_low_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> dataOut == '0);

endmodule

bind cam_match_port cam_match_checker #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startStrobe (startStrobe),
  .atmMode     (atmMode),
  .outEnable   (outEnable),
  .matchDone   (matchDone),
  .matchHit    (matchHit),
  .virtPathHit (virtPathHit),
  .dataOut     (dataOut)
);

// File: tb/cam_match_port_tb_top.sv
module cam_match_port_tb_top;

  localparam int ENTRIES = 16;
  localparam int MATCH_W = 32;
  localparam int KEY_W   = 64;
  localparam int DATA_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [MATCH_W-1:0] matchBus = '0;
  logic startStrobe = 1'b0;
  logic lowStrobe = 1'b0;
  logic wideMode = 1'b0;
  logic atmMode = 1'b0;
  logic outEnable = 1'b1;
  logic [ENTRIES*KEY_W-1:0]  entryKeys = '0;
  logic [ENTRIES-1:0]        entryValid = '0;
  logic [ENTRIES-1:0]        entryVirtPath = '0;
  logic [ENTRIES*DATA_W-1:0] entryData = '0;
  logic matchDone;
  logic matchHit;
  logic virtPathHit;
  logic [DATA_W-1:0] dataOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cam_match_port #(
    .ENTRIES(ENTRIES), .MATCH_W(MATCH_W), .KEY_W(KEY_W), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .matchBus(matchBus), .startStrobe(startStrobe),
    .lowStrobe(lowStrobe), .wideMode(wideMode), .atmMode(atmMode),
    .outEnable(outEnable), .entryKeys(entryKeys), .entryValid(entryValid),
    .entryVirtPath(entryVirtPath), .entryData(entryData),
    .matchDone(matchDone), .matchHit(matchHit), .virtPathHit(virtPathHit),
    .dataOut(dataOut)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setEntry(int idx, bit vld, bit vp, logic [63:0] key, logic [15:0] dat);
    entryKeys[idx*KEY_W +: KEY_W]   = key;
    entryValid[idx]                 = vld;
    entryVirtPath[idx]              = vp;
    entryData[idx*DATA_W +: DATA_W] = dat;
  endtask

  task automatic latchLow(logic [31:0] word);
    @(negedge clk);
    lowStrobe = 1'b1;
    matchBus  = word;
    @(negedge clk);
    lowStrobe = 1'b0;
    matchBus  = 32'h0BAD_0BAD;
  endtask

  // holdStrobe=1: strobe two cycles, key one; 0: strobe one cycle, key two
  task automatic runMatch(string tag, bit holdStrobe, logic [31:0] key,
                          bit expHit, bit expVp, logic [15:0] expData);
    @(negedge clk);
    startStrobe = 1'b1;
    matchBus    = key;
    @(negedge clk);
    if (holdStrobe) matchBus = 32'h4000_0004;  // junk that would hit entry 4
    else            startStrobe = 1'b0;
    @(negedge clk);
    startStrobe = 1'b0;
    matchBus    = 32'h4000_0004;
    check({tag, " R2 early"}, 64'(matchDone), 64'd0);
    @(negedge clk);
    check({tag, " R2 pulse"}, 64'(matchDone), 64'd1);
    check({tag, " R3 hit"}, 64'(matchHit), 64'(expHit));
    check({tag, " R4 vp"}, 64'(virtPathHit), 64'(expVp));
    check({tag, " R5 data"}, 64'(dataOut), 64'(expData));
    @(negedge clk);
    check({tag, " R1 single pulse"}, 64'(matchDone), 64'd0);
    check({tag, " R3 hit low"}, 64'(matchHit), 64'd0);
    check({tag, " R6 data held"}, 64'(dataOut), 64'(expData));
  endtask

  task automatic testReset();
    check("R10 done", 64'(matchDone), 64'd0);
    check("R10 hit", 64'(matchHit), 64'd0);
    check("R10 vp", 64'(virtPathHit), 64'd0);
    check("R10 data", 64'(dataOut), 64'd0);
  endtask

  task automatic testNarrow();
    wideMode = 1'b0;
    atmMode  = 1'b1;
    runMatch("R1 held strobe e0", 1'b1, 32'h1000_0001, 1'b1, 1'b0, 16'h00A0);
    runMatch("R8 R9 pulse strobe multi", 1'b0, 32'h2000_0002, 1'b1, 1'b1, 16'h00B1);
    runMatch("R9 held strobe multi", 1'b1, 32'h2000_0002, 1'b1, 1'b1, 16'h00B1);
    atmMode = 1'b0;
    runMatch("R4 atm off", 1'b0, 32'h2000_0002, 1'b1, 1'b0, 16'h00B1);
  endtask

  task automatic testMiss();
    atmMode = 1'b1;
    runMatch("R11 invalid entry", 1'b0, 32'h3000_0003, 1'b0, 1'b0, 16'h0000);
    runMatch("R11 absent key", 1'b1, 32'h7777_7777, 1'b0, 1'b0, 16'h0000);
  endtask

  task automatic testOutEnable();
    atmMode = 1'b1;
    runMatch("R6 e4", 1'b0, 32'h4000_0004, 1'b1, 1'b1, 16'h00E4);
    @(negedge clk);
    outEnable = 1'b0;
    #1 check("R6 oe low", 64'(dataOut), 64'd0);
    @(negedge clk);
    outEnable = 1'b1;
    #1 check("R6 oe high", 64'(dataOut), 64'h00E4);
  endtask

  task automatic testWide();
    wideMode = 1'b1;
    atmMode  = 1'b1;
    latchLow(32'h2000_0002);
    runMatch("R7 wide e5", 1'b0, 32'h5555_5555, 1'b1, 1'b0, 16'h00F5);
    runMatch("R7 wide e2", 1'b1, 32'h0000_0000, 1'b1, 1'b0, 16'h00C2);
    runMatch("R7 wide e1", 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 16'h00B1);
    runMatch("R7 wide miss", 1'b0, 32'h1234_5678, 1'b0, 1'b0, 16'h0000);
    latchLow(32'h1000_0001);
    runMatch("R7 new low e0", 1'b1, 32'h0000_0000, 1'b1, 1'b0, 16'h00A0);
    wideMode = 1'b0;
  endtask

  initial begin
    setEntry(0, 1'b1, 1'b0, {32'h0000_0000, 32'h1000_0001}, 16'h00A0);
    setEntry(1, 1'b1, 1'b1, {32'hDEAD_BEEF, 32'h2000_0002}, 16'h00B1);
    setEntry(2, 1'b1, 1'b0, {32'h0000_0000, 32'h2000_0002}, 16'h00C2);
    setEntry(3, 1'b0, 1'b0, {32'h0000_0000, 32'h3000_0003}, 16'h00D3);
    setEntry(4, 1'b1, 1'b1, {32'h0000_0000, 32'h4000_0004}, 16'h00E4);
    setEntry(5, 1'b1, 1'b0, {32'h5555_5555, 32'h2000_0002}, 16'h00F5);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNarrow();
    testMiss();
    testOutEnable();
    testWide();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule